// File: doc/BRIEF.md
# Black-Level Offset Servo

This block keeps the black level of a digitized video channel on a chosen code. At the end of every clamp interval the converter's output code is presented on a small valid/ready input. The block compares that code with a target and nudges an offset word that feeds the analog offset stage upstream. The next clamp then reads closer to the target, and the loop settles over a number of clamps.

Several settings shape how the correction is computed and applied:
- A pacing field sets how often a correction is applied.
- A shift scales the error down before it is used.
- A slew bound caps each step.
- An optional jump moves straight to the predicted value when the error is large.
- A vote filter waits for six agreeing corrections before it acts.
- An anti-toggle filter stops the word from bouncing between two values.
- A hold input freezes the word.

With automatic mode off, a manually supplied word is passed straight through.

The measurement input accepts a code whenever `meas_valid` is high. `meas_ready` is tied high, so the block never back-pressures the source. A code is consumed on every cycle where both signals are high. The frame strobe is a plain single-cycle pulse.

Top module: `aoc_offset_ctrl`

## Requirements
- R1: While `auto_en` is 0, `ofs_out` equals `manual_ofs` in the same cycle. The internal word is loaded from `manual_ofs`, and all pacing and filter history is cleared. Automatic operation therefore starts from the manual value.
- R2: `pace_mode` sets when an update happens.
  - 0: every accepted code.
  - 1: every 16th accepted code.
  - 2: every 64th accepted code.
  - 3: on each `frame_strobe`, using the newest accepted code. If a code is accepted in the same cycle as the strobe, that code is used. Nothing happens until at least one code has been accepted.
  - The clamp counter is cleared on reset and while `auto_en` is 0.
- R3: The error is `target_code - code`, taken as a signed value. `err_shift` values 0, 1, 2 and 3 scale it by an arithmetic right shift of 0, 1, 2 or 3 bits. The result is added to the offset.
- R4: Without a jump, one update never moves the offset by more than `slew_limit` in either direction.
- R5: With `jump_en` set and |error| > 15, the offset moves by the full error. Both the shift and the slew bound are bypassed. An error of exactly 15 takes the normal path.
- R6: The offset saturates at 0 and at 255 instead of wrapping.
- R7: With `vote_en` set, the offset changes only on the sixth of six consecutive updates that all move it in the same direction. That sixth update's value is applied. An update that moves nothing, or moves the other way, restarts the count.
- R8: With `toggle_en` set, an update is suppressed when two conditions hold together:
  - it moves opposite to the last applied change;
  - it would restore the value the offset held before that change.
- R9: While `hold` is 1, the offset does not change and the vote filter state is frozen. The clamp counter keeps counting.
- R10: `meas_ready` is always 1. A code with `meas_valid` low has no effect on the offset, and neither does a frame strobe in modes 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meas_valid | input | 1 | Clamp-end code valid |
| meas_ready | output | 1 | Always 1 |
| meas_code | input | 8 | Code measured during clamp |
| frame_strobe | input | 1 | One pulse per frame |
| target_code | input | 8 | Desired black-level code |
| auto_en | input | 1 | 1 = closed loop, 0 = manual |
| hold | input | 1 | Freeze the offset |
| pace_mode | input | 2 | Update rate select |
| err_shift | input | 2 | Error right-shift amount |
| jump_en | input | 1 | Allow a direct jump on a large error |
| vote_en | input | 1 | Six-vote filter enable |
| toggle_en | input | 1 | Anti-toggle filter enable |
| slew_limit | input | 8 | Largest step per update |
| manual_ofs | input | 8 | Manual offset word |
| ofs_out | output | 8 | Offset word to the analog stage |

## Verification
In automatic mode a new offset appears after the rising edge that samples the triggering code or frame strobe. In manual mode `ofs_out` follows `manual_ofs` with no register in between. The bench drives inputs on the falling edge and lets exactly one rising edge pass. Its own model then advances by that edge, and `ofs_out` is compared at the next falling edge. Every cycle is compared this way. The directed cases also test hand-computed values at the exact clamp that should trigger a change, for example the 16th and 64th codes, or the sixth vote. They also check the cycle just before that clamp.

// File: rtl/aoc_pkg.sv
package aoc_pkg;
  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DN   = 2'd2
  } dir_e;

  typedef enum logic [1:0] {
    PACE_EACH  = 2'd0,
    PACE_MID   = 2'd1,
    PACE_SLOW  = 2'd2,
    PACE_FRAME = 2'd3
  } pace_e;
endpackage

// File: rtl/aoc_pacer.sv
module aoc_pacer
  import aoc_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int MID_N  = 16,
  parameter int SLOW_N = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  pace_e             mode,
  input  logic              meas_fire,
  input  logic [CODE_W-1:0] meas_code,
  input  logic              frame,
  output logic              upd,
  output logic [CODE_W-1:0] upd_code
);
  localparam int CNT_W = $clog2(SLOW_N + 1);
  localparam logic [CNT_W-1:0] MID_LAST  = CNT_W'(MID_N - 1);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_N - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  lim;
  logic              cnt_hit;
  logic              have_q;
  logic [CODE_W-1:0] last_q;

  always_comb begin
    case (mode)
      PACE_MID:  lim = MID_LAST;
      PACE_SLOW: lim = SLOW_LAST;
      default:   lim = '0;
    endcase
    cnt_hit = (cnt_q >= lim);
    if (mode == PACE_FRAME) begin
      upd      = run && frame && (have_q || meas_fire);
      upd_code = meas_fire ? meas_code : last_q;
    end else begin
      upd      = run && meas_fire && cnt_hit;
      upd_code = meas_code;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q  <= '0;
      have_q <= 1'b0;
      last_q <= '0;
    end else if (meas_fire) begin
      last_q <= meas_code;
      have_q <= 1'b1;
      if (mode != PACE_FRAME) cnt_q <= cnt_hit ? '0 : cnt_q + 1'b1;
    end
  end

  assert_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> ((mode == PACE_FRAME) ? frame : meas_fire));

  assert_mid_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && mode == PACE_MID && $past(run) && $past(mode) == PACE_MID)
      |-> $past(!meas_fire || !cnt_hit));
endmodule

// File: rtl/aoc_step.sv
module aoc_step
  import aoc_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int OFS_W   = 8,
  parameter int SLEW_W  = 8,
  parameter int JUMP_TH = 15
) (
  input  logic [OFS_W-1:0]  ofs,
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] target,
  input  logic [1:0]        shift,
  input  logic              jump_en,
  input  logic [SLEW_W-1:0] slew,
  output logic [OFS_W-1:0]  nxt,
  output dir_e              dir
);
  localparam int DW = ((CODE_W > OFS_W) ? CODE_W : OFS_W) + 2;

  logic signed [DW-1:0] err, mag, scaled, slew_s, step_v, sum, top_s;

  always_comb begin
    err    = $signed(DW'(target)) - $signed(DW'(code));
    mag    = err[DW-1] ? -err : err;
    scaled = err >>> shift;
    slew_s = $signed(DW'(slew));
    if (jump_en && (mag > $signed(DW'(JUMP_TH))))
      step_v = err;
    else if (scaled > slew_s)
      step_v = slew_s;
    else if (scaled < -slew_s)
      step_v = -slew_s;
    else
      step_v = scaled;
    sum   = $signed(DW'(ofs)) + step_v;
    top_s = $signed(DW'({OFS_W{1'b1}}));
    if (sum < 0)
      nxt = '0;
    else if (sum > top_s)
      nxt = '1;
    else
      nxt = sum[OFS_W-1:0];
    if (nxt > ofs)
      dir = DIR_UP;
    else if (nxt < ofs)
      dir = DIR_DN;
    else
      dir = DIR_NONE;
  end
endmodule

// File: rtl/aoc_vote.sv
module aoc_vote
  import aoc_pkg::*;
#(
  parameter int VOTES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic en,
  input  logic upd,
  input  dir_e dir,
  output logic pass
);
  localparam int VW = $clog2(VOTES + 1);
  localparam logic [VW-1:0] LAST = VW'(VOTES - 1);

  logic [VW-1:0] cnt_q;
  dir_e          dir_q;
  logic          agree;

  always_comb begin
    agree = (dir != DIR_NONE) && (cnt_q != '0) && (dir == dir_q);
    pass  = en ? (upd && agree && (cnt_q == LAST)) : upd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run || !en) begin
      cnt_q <= '0;
      dir_q <= DIR_NONE;
    end else if (upd) begin
      if (dir == DIR_NONE)
        cnt_q <= '0;
      else if (agree)
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      else begin
        cnt_q <= VW'(1);
        dir_q <= dir;
      end
    end
  end

  assert_vote_still_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && en && upd && dir == DIR_NONE) |-> !pass);

  assert_vote_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && en && pass) |=> (cnt_q == '0));
endmodule

// File: rtl/aoc_offset_ctrl.sv
module aoc_offset_ctrl
  import aoc_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int OFS_W   = 8,
  parameter int SLEW_W  = 8,
  parameter int MID_N   = 16,
  parameter int SLOW_N  = 64,
  parameter int VOTES   = 6,
  parameter int JUMP_TH = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              meas_valid,
  output logic              meas_ready,
  input  logic [CODE_W-1:0] meas_code,
  input  logic              frame_strobe,
  input  logic [CODE_W-1:0] target_code,
  input  logic              auto_en,
  input  logic              hold,
  input  logic [1:0]        pace_mode,
  input  logic [1:0]        err_shift,
  input  logic              jump_en,
  input  logic              vote_en,
  input  logic              toggle_en,
  input  logic [SLEW_W-1:0] slew_limit,
  input  logic [OFS_W-1:0]  manual_ofs,
  output logic [OFS_W-1:0]  ofs_out
);
  logic              meas_fire;
  logic              upd, upd_eff, pass, toggle_hit, apply;
  logic [CODE_W-1:0] upd_code;
  logic [OFS_W-1:0]  nxt;
  dir_e              dir;
  logic [OFS_W-1:0]  ofs_q, pre_q;
  dir_e              ldir_q;
  logic              hist_q;

  assign meas_ready = 1'b1;
  assign meas_fire  = meas_valid && meas_ready;

  aoc_pacer #(.CODE_W(CODE_W), .MID_N(MID_N), .SLOW_N(SLOW_N)) u_pacer (
    .clk(clk), .rst_n(rst_n), .run(auto_en), .mode(pace_e'(pace_mode)),
    .meas_fire(meas_fire), .meas_code(meas_code), .frame(frame_strobe),
    .upd(upd), .upd_code(upd_code)
  );

  assign upd_eff = upd && !hold;

  aoc_step #(.CODE_W(CODE_W), .OFS_W(OFS_W), .SLEW_W(SLEW_W), .JUMP_TH(JUMP_TH)) u_step (
    .ofs(ofs_q), .code(upd_code), .target(target_code), .shift(err_shift),
    .jump_en(jump_en), .slew(slew_limit), .nxt(nxt), .dir(dir)
  );

  aoc_vote #(.VOTES(VOTES)) u_vote (
    .clk(clk), .rst_n(rst_n), .run(auto_en), .en(vote_en),
    .upd(upd_eff), .dir(dir), .pass(pass)
  );

  always_comb begin
    toggle_hit = toggle_en && hist_q && (dir != DIR_NONE) && (dir != ldir_q) && (nxt == pre_q);
    apply      = pass && (dir != DIR_NONE) && !toggle_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs_q  <= '0;
      pre_q  <= '0;
      ldir_q <= DIR_NONE;
      hist_q <= 1'b0;
    end else if (!auto_en) begin
      ofs_q  <= manual_ofs;
      pre_q  <= manual_ofs;
      ldir_q <= DIR_NONE;
      hist_q <= 1'b0;
    end else if (apply) begin
      pre_q  <= ofs_q;
      ofs_q  <= nxt;
      ldir_q <= dir;
      hist_q <= 1'b1;
    end
  end

  assign ofs_out = auto_en ? ofs_q : manual_ofs;

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && hold) |=> $stable(ofs_q));

  assert_slew_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !jump_en) |=>
      (((ofs_q >= $past(ofs_q)) ? (ofs_q - $past(ofs_q)) : ($past(ofs_q) - ofs_q))
        <= $past(slew_limit)));

  assert_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && toggle_hit) |=> $stable(ofs_q));

  assert_manual_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> (ofs_q == $past(manual_ofs)));
endmodule

// File: tb/aoc_offset_ctrl_test.sv
module aoc_offset_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       meas_valid, meas_ready, frame_strobe;
  logic [7:0] meas_code, target_code, slew_limit, manual_ofs, ofs_out;
  logic       auto_en, hold, jump_en, vote_en, toggle_en;
  logic [1:0] pace_mode, err_shift;

  int total = 0;
  int fails = 0;
  string tag = "R1";

  int m_ofs, m_pre, m_ldir, m_hist, m_cnt, m_have, m_last, pf_cnt, pf_dir;

  always #2 clk = ~clk;

  aoc_offset_ctrl uut (
    .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_ready(meas_ready),
    .meas_code(meas_code), .frame_strobe(frame_strobe), .target_code(target_code),
    .auto_en(auto_en), .hold(hold), .pace_mode(pace_mode), .err_shift(err_shift),
    .jump_en(jump_en), .vote_en(vote_en), .toggle_en(toggle_en),
    .slew_limit(slew_limit), .manual_ofs(manual_ofs), .ofs_out(ofs_out)
  );

  task automatic chk(input string t, input int got, input int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", t, got, exp, $time);
    end
  endtask

  function automatic int step_ref(input int ofs, input int code, input int tgt,
                                  input int sh, input int jmp, input int slew);
    int err, d, n;
    err = tgt - code;
    if (jmp != 0 && (err > 15 || err < -15)) d = err;
    else begin
      d = err >>> sh;
      if (d > slew) d = slew;
      if (d < -slew) d = -slew;
    end
    n = ofs + d;
    if (n < 0) n = 0;
    if (n > 255) n = 255;
    return n;
  endfunction

  task automatic model_edge();
    int upd, code, lim, nxt, dir, pass;
    if (!rst_n || !auto_en) begin
      m_ofs = rst_n ? int'(manual_ofs) : 0;
      m_pre = m_ofs; m_ldir = 0; m_hist = 0;
      m_cnt = 0; m_have = 0; m_last = 0; pf_cnt = 0; pf_dir = 0;
      return;
    end
    upd = 0;
    code = int'(meas_code);
    if (pace_mode == 2'd3) begin
      if (frame_strobe && (m_have != 0 || meas_valid)) upd = 1;
      code = meas_valid ? int'(meas_code) : m_last;
    end else begin
      lim = (pace_mode == 2'd0) ? 0 : (pace_mode == 2'd1) ? 15 : 63;
      if (meas_valid && m_cnt >= lim) upd = 1;
      if (meas_valid) m_cnt = (m_cnt >= lim) ? 0 : m_cnt + 1;
    end
    if (meas_valid) begin m_last = int'(meas_code); m_have = 1; end
    if (hold) upd = 0;
    if (!vote_en) begin pf_cnt = 0; pf_dir = 0; end
    if (upd == 0) return;
    nxt = step_ref(m_ofs, code, int'(target_code), int'(err_shift), int'(jump_en), int'(slew_limit));
    dir = (nxt > m_ofs) ? 1 : (nxt < m_ofs) ? 2 : 0;
    if (!vote_en) pass = 1;
    else begin
      pass = 0;
      if (dir == 0) pf_cnt = 0;
      else if (pf_cnt != 0 && dir == pf_dir) begin
        if (pf_cnt == 5) begin pass = 1; pf_cnt = 0; end
        else pf_cnt++;
      end else begin pf_cnt = 1; pf_dir = dir; end
    end
    if (pass == 0 || dir == 0) return;
    if (toggle_en && m_hist != 0 && dir != m_ldir && nxt == m_pre) return;
    m_pre = m_ofs; m_ofs = nxt; m_ldir = dir; m_hist = 1;
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, int'(ofs_out), auto_en ? m_ofs : int'(manual_ofs));
  endtask

  task automatic meas(input int code, input int n);
    for (int i = 0; i < n; i++) begin
      meas_valid = 1'b1; meas_code = 8'(code); frame_strobe = 1'b0;
      tick();
    end
    meas_valid = 1'b0;
  endtask

  task automatic reload(input int m);
    auto_en = 1'b0; manual_ofs = 8'(m); meas_valid = 1'b0; frame_strobe = 1'b0;
    tick();
    auto_en = 1'b1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    fails++; total++;
    $display("FAIL R2 watchdog expired: got hung expected finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; meas_valid = 1'b0; meas_code = '0; frame_strobe = 1'b0;
    target_code = 8'd50; auto_en = 1'b0; hold = 1'b0; pace_mode = 2'd0;
    err_shift = 2'd1; jump_en = 1'b0; vote_en = 1'b0; toggle_en = 1'b0;
    slew_limit = 8'd20; manual_ofs = 8'h5A;
    void'($urandom(32'd4242));
    @(negedge clk);
    tick(); tick();
    chk("R1 reset", int'(ofs_out), 90);
    chk("R10 ready", int'(meas_ready), 1);
    rst_n = 1'b1;

    tag = "R1"; manual_ofs = 8'd77; tick();
    chk("R1 manual", int'(ofs_out), 77);
    manual_ofs = 8'd100; tick();

    tag = "R3"; auto_en = 1'b1; meas(44, 1);
    chk("R3 half-step", int'(ofs_out), 103);
    tag = "R4"; err_shift = 2'd0; slew_limit = 8'd5; meas(30, 1);
    chk("R4 slew", int'(ofs_out), 108);
    tag = "R5"; jump_en = 1'b1; err_shift = 2'd3; meas(30, 1);
    chk("R5 jump", int'(ofs_out), 128);
    err_shift = 2'd2; slew_limit = 8'd20; meas(35, 1);
    chk("R5 threshold", int'(ofs_out), 131);

    tag = "R6"; reload(250); meas(0, 1);
    chk("R6 top", int'(ofs_out), 255);
    jump_en = 1'b0; err_shift = 2'd0; slew_limit = 8'd8;
    reload(3); meas(60, 1);
    chk("R6 bottom", int'(ofs_out), 0);

    tag = "R2"; slew_limit = 8'd20; pace_mode = 2'd1; reload(100);
    meas(40, 15); chk("R2 mid before", int'(ofs_out), 100);
    meas(40, 1);  chk("R2 mid hit", int'(ofs_out), 110);
    pace_mode = 2'd2;
    meas(40, 63); chk("R2 slow before", int'(ofs_out), 110);
    meas(40, 1);  chk("R2 slow hit", int'(ofs_out), 120);
    pace_mode = 2'd3;
    meas(40, 3);  chk("R2 frame wait", int'(ofs_out), 120);
    frame_strobe = 1'b1; tick(); chk("R2 frame", int'(ofs_out), 130);
    tick(); chk("R2 frame again", int'(ofs_out), 140);
    frame_strobe = 1'b0;

    tag = "R7"; pace_mode = 2'd0; vote_en = 1'b1; reload(100);
    meas(40, 5); chk("R7 five votes", int'(ofs_out), 100);
    meas(40, 1); chk("R7 sixth vote", int'(ofs_out), 110);
    meas(60, 1); meas(40, 5); chk("R7 restart", int'(ofs_out), 110);
    meas(40, 1); chk("R7 after restart", int'(ofs_out), 120);

    tag = "R8"; vote_en = 1'b0; toggle_en = 1'b1; reload(100);
    meas(48, 1); chk("R8 first", int'(ofs_out), 102);
    meas(52, 2); chk("R8 held", int'(ofs_out), 102);
    toggle_en = 1'b0; meas(52, 1); chk("R8 off", int'(ofs_out), 100);

    tag = "R9"; hold = 1'b1; meas(40, 3); chk("R9 hold", int'(ofs_out), 100);
    hold = 1'b0; meas(40, 1); chk("R9 release", int'(ofs_out), 110);

    tag = "R10"; meas_valid = 1'b0; meas_code = 8'd0; frame_strobe = 1'b1;
    tick(); tick(); frame_strobe = 1'b0;
    chk("R10 ignored", int'(ofs_out), 110);

    tag = "R3 random";
    for (int seg = 0; seg < 20; seg++) begin
      pace_mode   = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
      err_shift   = 2'($urandom_range(0, 3));
      jump_en     = 1'($urandom_range(0, 1));
      vote_en     = 1'($urandom_range(0, 1));
      toggle_en   = 1'($urandom_range(0, 1));
      slew_limit  = 8'($urandom_range(1, 24));
      target_code = 8'($urandom_range(20, 235));
      for (int c = 0; c < 200; c++) begin
        int code;
        code = int'(target_code) + int'($urandom_range(0, 60)) - 30;
        meas_valid   = ($urandom_range(0, 1) == 1);
        meas_code    = 8'(code);
        frame_strobe = ($urandom_range(0, 19) == 0);
        hold         = ($urandom_range(0, 19) == 0);
        auto_en      = ($urandom_range(0, 49) != 0);
        manual_ofs   = 8'($urandom_range(0, 255));
        tick();
      end
    end
    finish_run();
  end
endmodule